// File: doc/BRIEF.md
# Calibration Coefficient Access Controller

This block sits behind a 16-bit register port and gives software access to a small nonvolatile store of per-channel gain and offset trim values. Each analog channel keeps its offset and its gain at separate byte addresses in a 128-byte coefficient array. The array is modelled here as a synchronous byte memory with a fixed access time. At power-up it holds a computable preset pattern, so that values read back can be predicted.

Software launches every access with a single write to a write-only command word. Bit 15 of that word chooses the direction: 1 means read and 0 means write. Bits 14:8 give the coefficient address, and bits 7:0 give the byte to store. The controller then runs the access for a parameterised number of clock cycles. A status word reports progress through two flags, "write in progress" and "read finished", and carries the fetched byte in its upper half.

Writes to the array are refused unless a reserved key byte holds the unlock code 0xA5. Writing any other code to the key byte locks the array again.

Top module: `cal_coef_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000 and the array is locked.
- R2: A full-word write to offset 0x214 with bit 15 = 1, issued while the controller is idle, reads the byte at address bits 14:8. Exactly LATENCY cycles after the command edge, the read-finished flag is 1 and status bits 15:8 hold that byte. Before that edge the read-finished flag is 0.
- R3: The status word at offset 0x218 is laid out as follows: bits 15:8 hold the last fetched byte, bit 1 is write-in-progress, bit 0 is read-finished, and bits 7:2 read as 0.
- R4: Every accepted command clears the read-finished flag on the following cycle.
- R5: After reset, array byte a holds ((3*a) mod 256) XOR 0x5A.
- R6: When the array is unlocked, a full-word command with bit 15 = 0 sets write-in-progress for exactly LATENCY cycles. The low byte of the command is then stored at address bits 14:8.
- R7: When the array is locked, a write command is ignored. Write-in-progress stays 0, read-finished keeps its value, and the array is unchanged.
- R8: The key byte is bits 15:8 of the word at offset 0x244 and is written when byte lane 1 is enabled. The value 0xA5 unlocks the array, and any other value locks it.
- R9: A command issued while an access is in progress is rejected. A write in progress continues to completion with write-in-progress still set, and the rejected command has no effect.
- R10: A command takes effect only when both byte lanes are enabled. The command offset and all offsets other than the status word read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_be | input | 2 | Byte-lane enables (bit 1 = upper byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |

## Verification
The assertions check on every cycle the following properties:
- The write-in-progress flag lasts exactly LATENCY cycles.
- A command arriving mid-access is never accepted.
- Every accepted command clears read-finished.
- A locked write never raises write-in-progress.
- The two flags are never set together.
- The fetched byte holds steady while read-finished stays set.

Several behaviours can only be shown by the bench scenarios, because they depend on memory contents: the actual byte values returned, the preset pattern, whether a refused write really left the array untouched, and the effect of the key codes.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned BUS_AW  = 12;
  localparam int unsigned BUS_DW  = 16;
  localparam int unsigned COEF_AW = 7;
  localparam int unsigned COEF_DW = 8;

  localparam logic [BUS_AW-1:0] OFS_CMD  = 12'h214;
  localparam logic [BUS_AW-1:0] OFS_STAT = 12'h218;
  localparam logic [BUS_AW-1:0] OFS_KEY  = 12'h244;

  localparam logic [COEF_DW-1:0] UNLOCK_CODE = 8'hA5;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic               rnw;
    logic [COEF_AW-1:0] addr;
    logic [COEF_DW-1:0] wdata;
  } cmd_t;

  // Power-up content of the coefficient array.
  function automatic logic [COEF_DW-1:0] preset_byte(input logic [COEF_AW-1:0] a);
    logic [COEF_DW-1:0] w;
    w = {1'b0, a};
    return (w * 8'd3) ^ 8'h5A;
  endfunction

  function automatic cmd_t unpack_cmd(input logic [BUS_DW-1:0] w);
    return cmd_t'(w);
  endfunction

  function automatic logic [BUS_DW-1:0] pack_status(input logic [COEF_DW-1:0] d,
                                                    input logic busy,
                                                    input logic done);
    return {d, 6'b000000, busy, done};
  endfunction

endpackage

// File: rtl/cal_bus_decode.sv
module cal_bus_decode
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              cmd_fire,
  output cmd_t              cmd,
  output logic              key_wr,
  output logic              unlocked
);

  logic [COEF_DW-1:0] key_q;

  assign cmd_fire = bus_wr && (bus_addr == OFS_CMD) && (bus_be == 2'b11);
  assign cmd      = unpack_cmd(bus_wdata);
  assign key_wr   = bus_wr && (bus_addr == OFS_KEY) && bus_be[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (key_wr) begin
      key_q <= bus_wdata[BUS_DW-1 -: COEF_DW];
    end
  end

  assign unlocked = (key_q == UNLOCK_CODE);

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_pkg::*;
#(
  parameter int unsigned LATENCY = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_fire,
  input  cmd_t               cmd,
  input  logic               unlocked,
  input  logic [COEF_DW-1:0] mem_q,
  output logic               cmd_accept,
  output logic               seq_busy,
  output logic               access_done,
  output logic               wr_busy,
  output logic               rd_done,
  output logic [COEF_DW-1:0] rd_byte,
  output logic [COEF_AW-1:0] mem_addr,
  output logic               mem_we,
  output logic [COEF_DW-1:0] mem_wdata
);

  localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [COEF_AW-1:0] addr_q;
  logic [COEF_DW-1:0] wdata_q;
  logic               done_q;
  logic [COEF_DW-1:0] byte_q;

  assign seq_busy    = (state_q != SQ_IDLE);
  assign cmd_accept  = cmd_fire && !seq_busy && (cmd.rnw || unlocked);
  assign access_done = seq_busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (cmd_accept) begin
            state_q <= cmd.rnw ? SQ_READ : SQ_WRITE;
            cnt_q   <= CNT_LOAD;
            addr_q  <= cmd.addr;
            wdata_q <= cmd.wdata;
            done_q  <= 1'b0;
          end
        end
        SQ_READ, SQ_WRITE: begin
          if (access_done) begin
            state_q <= SQ_IDLE;
            if (state_q == SQ_READ) begin
              byte_q <= mem_q;
              done_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign wr_busy   = (state_q == SQ_WRITE);
  assign rd_done   = done_q;
  assign rd_byte   = byte_q;
  assign mem_addr  = addr_q;
  assign mem_we    = (state_q == SQ_WRITE) && access_done;
  assign mem_wdata = wdata_q;

endmodule

// File: rtl/cal_mem_model.sv
module cal_mem_model
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COEF_AW-1:0] addr,
  input  logic               we,
  input  logic [COEF_DW-1:0] wdata,
  output logic [COEF_DW-1:0] q
);

  localparam int unsigned DEPTH = 1 << COEF_AW;

  logic [COEF_DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= preset_byte(COEF_AW'(i));
      end
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign q = mem_q[addr];

endmodule

// File: rtl/cal_coef_ctrl.sv
module cal_coef_ctrl
  import cal_pkg::*;
#(
  parameter int unsigned LATENCY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata
);

  cmd_t               cmd;
  logic               cmd_fire;
  logic               cmd_accept;
  logic               key_wr;
  logic               unlocked;
  logic               seq_busy;
  logic               access_done;
  logic               wr_busy;
  logic               rd_done;
  logic [COEF_DW-1:0] rd_byte;
  logic [COEF_AW-1:0] mem_addr;
  logic               mem_we;
  logic [COEF_DW-1:0] mem_wdata;
  logic [COEF_DW-1:0] mem_q;

  cal_bus_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .cmd_fire  (cmd_fire),
    .cmd       (cmd),
    .key_wr    (key_wr),
    .unlocked  (unlocked)
  );

  cal_sequencer #(.LATENCY(LATENCY)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_fire    (cmd_fire),
    .cmd         (cmd),
    .unlocked    (unlocked),
    .mem_q       (mem_q),
    .cmd_accept  (cmd_accept),
    .seq_busy    (seq_busy),
    .access_done (access_done),
    .wr_busy     (wr_busy),
    .rd_done     (rd_done),
    .rd_byte     (rd_byte),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata)
  );

  cal_mem_model u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (mem_addr),
    .we    (mem_we),
    .wdata (mem_wdata),
    .q     (mem_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_STAT) begin
      bus_rdata = pack_status(rd_byte, wr_busy, rd_done);
    end
  end

endmodule

// File: rtl/cal_coef_ctrl_chk.sv
module cal_coef_ctrl_chk #(
  parameter int unsigned LATENCY = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_fire,
  input logic       cmd_rnw,
  input logic       cmd_accept,
  input logic       unlocked,
  input logic       seq_busy,
  input logic       wr_busy,
  input logic       rd_done,
  input logic [7:0] rd_byte
);

  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else if (wr_busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> busy_len == LATENCY);

  p_reject_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && seq_busy) |-> !cmd_accept);

  p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !rd_done);

  p_locked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !cmd_rnw && !unlocked && !seq_busy) |=> !wr_busy);

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_busy && rd_done));

  p_byte_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && $past(rd_done)) |-> $stable(rd_byte));

endmodule

bind cal_coef_ctrl cal_coef_ctrl_chk #(.LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_fire   (cmd_fire),
  .cmd_rnw    (cmd.rnw),
  .cmd_accept (cmd_accept),
  .unlocked   (unlocked),
  .seq_busy   (seq_busy),
  .wr_busy    (wr_busy),
  .rd_done    (rd_done),
  .rd_byte    (rd_byte)
);

// File: tb/cal_coef_ctrl_test.sv
module cal_coef_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 8;
  localparam logic [11:0] A_CMD  = 12'h214;
  localparam logic [11:0] A_STAT = 12'h218;
  localparam logic [11:0] A_KEY  = 12'h244;
  localparam int NVEC = 8;
  localparam logic [6:0] VEC_ADDR [NVEC] =
    '{7'h00, 7'h01, 7'h02, 7'h10, 7'h2A, 7'h55, 7'h7E, 7'h7F};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = A_STAT;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  cal_coef_ctrl #(.LATENCY(LAT)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Power-up byte restated: 3a = 2a + a, truncated to 8 bits.
  function automatic logic [7:0] expect_preset(input logic [6:0] a);
    logic [8:0] s;
    s = ({2'b00, a} << 1) + {2'b00, a};
    return s[7:0] ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00; bus_addr = A_STAT;
  endtask

  task automatic status(output logic [15:0] s);
    bus_addr = A_STAT;
    #1 s = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_coef(input logic [6:0] a, output logic [15:0] s);
    wr(A_CMD, 2'b11, {1'b1, a, 8'h00});
    idle(LAT);
    status(s);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] s;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    status(s);
    check("R1 reset status", s, 16'h0000);
    // R10: command offset reads zero
    bus_addr = A_CMD;
    #1 check("R10 cmd reads zero", bus_rdata, 16'h0000);
    bus_addr = A_STAT;

    // Vector walk: read each address, check timing and value (R2 R3 R5)
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CMD, 2'b11, {1'b1, VEC_ADDR[i], 8'hC3});
      idle(LAT - 1);
      status(s);
      check("R2 not done before latency", {15'h0, s[0]}, 16'h0000);
      idle(1);
      status(s);
      check("R5 R3 R2 read value", s, {expect_preset(VEC_ADDR[i]), 8'h01});
    end

    // R4: accepted read clears read-finished on next cycle
    wr(A_CMD, 2'b11, {1'b1, 7'h03, 8'h00});
    status(s);
    check("R4 done cleared", {15'h0, s[0]}, 16'h0000);
    idle(LAT);

    // R7: locked write ignored
    wr(A_CMD, 2'b11, {1'b0, 7'h05, 8'h33});
    status(s);
    check("R7 locked no busy, done kept", s[1:0], 2'b01);
    idle(LAT + 1);
    rd_coef(7'h05, s);
    check("R7 array unchanged", s, {expect_preset(7'h05), 8'h01});

    // R8: wrong key keeps it locked
    wr(A_KEY, 2'b10, 16'h5A00);
    wr(A_CMD, 2'b11, {1'b0, 7'h05, 8'h33});
    status(s);
    check("R8 wrong key locked", s[1:0], 2'b01);
    idle(LAT + 1);
    // R8: key written through lower lane only has no effect
    wr(A_KEY, 2'b01, 16'hA5A5);
    wr(A_CMD, 2'b11, {1'b0, 7'h05, 8'h33});
    status(s);
    check("R8 low lane key ignored", s[1:0], 2'b01);
    idle(LAT + 1);

    // R6: unlock and write
    wr(A_KEY, 2'b10, 16'hA500);
    wr(A_CMD, 2'b11, {1'b0, 7'h05, 8'h33});
    status(s);
    check("R6 busy set, R4 done cleared", s[1:0], 2'b10);
    idle(LAT - 1);
    status(s);
    check("R6 busy held to latency", s[1:0], 2'b10);
    idle(1);
    status(s);
    check("R6 busy dropped at latency", s[1:0], 2'b00);
    rd_coef(7'h05, s);
    check("R6 written byte reads back", s, 16'h3301);

    // R9: command during write rejected
    wr(A_CMD, 2'b11, {1'b0, 7'h06, 8'h77});
    idle(1);
    wr(A_CMD, 2'b11, {1'b1, 7'h09, 8'h00});
    status(s);
    check("R9 busy stays", s[1:0], 2'b10);
    idle(LAT);
    status(s);
    check("R9 rejected read not done", s[1:0], 2'b00);
    rd_coef(7'h06, s);
    check("R9 write completed", s, 16'h7701);

    // R8: relock with another code
    wr(A_KEY, 2'b10, 16'h0000);
    wr(A_CMD, 2'b11, {1'b0, 7'h06, 8'h11});
    idle(LAT + 1);
    rd_coef(7'h06, s);
    check("R8 relocked", s, 16'h7701);

    // R10: partial-lane command ignored
    wr(A_CMD, 2'b01, {1'b1, 7'h00, 8'h00});
    status(s);
    check("R10 partial lane ignored", s, 16'h7701);
    idle(LAT + 1);
    status(s);
    check("R10 partial lane no read", s, 16'h7701);

    summary();
  end

endmodule